// File: doc/BRIEF.md
# Configurable Noise Shift-Register Voice

This block is the noise voice of a four-voice square-wave sound generator. A right-shifting linear feedback shift register produces either white noise or a short periodic pattern. On every shift event the register moves down one place and a feedback bit, formed from two tap positions, is placed at the top. Parameters set the register width (through the position of the feedback bit), the two tap positions, whether the second tap counts as active when it reads 0 instead of 1, whether a control write reloads the register always or only on a mode change, and whether the output bit is inverted. One netlist therefore covers several generator variants.

The shift rate comes from a down-counter clocked by the divided tick. The 3-bit control field picks a fixed division of 32, 64 or 128 ticks, or a rate locked to twice the period of tone voice 2, which follows that period as soon as it changes. The output is one bit for the downstream attenuator and mixer, which are outside this block.

Top module: `noise_lfsr_gen`

## Requirements
- R1: After reset the register holds only the feedback bit (bit FB_BIT set, all others clear), the rate counter is zero, the stored control field is 000, and noise_out equals INVERT_OUT.
- R2: With stored control bits [1:0] equal to 0, 1 or 2, a shift event happens on the first tick after the counter reaches 1 or less, and the counter then reloads with 32, 64 or 128 respectively; otherwise each tick lowers the counter by one.
- R3: With stored control bits [1:0] equal to 3, the reload value is twice the tone2_period input, taken at the time of the reload, so a change of tone2_period takes effect at the next reload without any control write.
- R4: With stored control bit 2 set (white noise), a shift moves the register right one place and sets the top bit to tap A XOR (tap B active); tap B is active when it reads 1, or when it reads 0 if TAPB_ACTIVE_LOW is set.
- R5: With stored control bit 2 clear (periodic), tap B is held inactive, so the top bit after a shift is tap A alone; with the default taps the single set bit circulates and noise_out is high for one shift period out of every FB_BIT+1.
- R6: With RELOAD_ON_MODE_CHANGE clear, every ctrl_we pulse stores ctrl and reloads the register with the feedback-bit value; a shift event in the same cycle is dropped.
- R7: With RELOAD_ON_MODE_CHANGE set, ctrl_we stores ctrl but reloads the register only when ctrl bit 2 differs from the stored mode bit; otherwise a same-cycle shift proceeds.
- R8: noise_out changes only on a shift event that is not overridden by a reload, and it then equals bit 0 of the shifted register XOR INVERT_OUT.
- R9: In a cycle with tick and ctrl_we both low, the register, counter and output do not change.
- R10: With rate 3 and tone2_period equal to 0, the register shifts on every tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Divided clock enable, one pulse per generator step |
| ctrl_we | input | 1 | Strobe that stores ctrl and may reload the register |
| ctrl | input | 3 | Bit 2: 1 white, 0 periodic; bits 1:0 rate select |
| tone2_period | input | TONE_W | Effective period of tone voice 2 |
| noise_out | output | 1 | Current noise bit for the mixer |

## Verification
On every cycle the assertions check that a shift never happens without a tick, that the top bit and the shifted-down bits follow the feedback rule, that a reload leaves exactly the feedback bit, that the mode-change-only variant ignores writes that keep the mode, and that the output holds between shifts and tracks bit 0 with the set polarity after each. Shift spacing for each rate, the live response to a new tone-2 period, the duty of the periodic pattern and the bit stream of two differently configured instances are shown only by the bench scenarios, which compare every cycle against a model of the requirements.

// File: rtl/noise_lfsr_pkg.sv
package noise_lfsr_pkg;

    typedef enum logic [1:0] {
        RATE_DIV32  = 2'd0,
        RATE_DIV64  = 2'd1,
        RATE_DIV128 = 2'd2,
        RATE_TONE2  = 2'd3
    } noise_rate_e;

    localparam int unsigned BASE_SHIFT_LOG2 = 5;

    typedef struct packed {
        logic        white;
        noise_rate_e rate;
    } noise_ctrl_t;

endpackage

// File: rtl/noise_rate_sel.sv
module noise_rate_sel
    import noise_lfsr_pkg::*;
#(
    parameter int unsigned TONE_W = 10,
    parameter int unsigned CNT_W  = TONE_W + 2
) (
    input  noise_rate_e       rate,
    input  logic [TONE_W-1:0] tone2_period,
    output logic [CNT_W-1:0]  period
);

    logic [CNT_W-1:0] fixed_period;
    logic [CNT_W-1:0] linked_period;

    always_comb begin
        fixed_period  = CNT_W'(1) << (BASE_SHIFT_LOG2 + 32'(rate));
        linked_period = CNT_W'({tone2_period, 1'b0});
        period        = (rate == RATE_TONE2) ? linked_period : fixed_period;
    end

endmodule

// File: rtl/noise_shift_timer.sv
module noise_shift_timer #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    output logic             shift_evt
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_t;

    timer_t st_d, st_q;
    logic   expire;

    always_comb begin
        st_d      = st_q;
        expire    = (st_q.cnt <= CNT_W'(1));
        shift_evt = tick && expire;
        if (tick) begin
            if (expire) st_d.cnt = period;
            else        st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/noise_lfsr_core.sv
module noise_lfsr_core #(
    parameter int unsigned FB_BIT                = 15,
    parameter int unsigned TAP_A                 = 0,
    parameter int unsigned TAP_B                 = 3,
    parameter bit          TAPB_ACTIVE_LOW       = 1'b0,
    parameter bit          RELOAD_ON_MODE_CHANGE = 1'b0,
    parameter bit          INVERT_OUT            = 1'b0,
    localparam int unsigned LFSR_W               = FB_BIT + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_evt,
    input  logic              white,
    input  logic              ctrl_we,
    input  logic              new_white,
    output logic              reload,
    output logic [LFSR_W-1:0] lfsr,
    output logic              noise_out
);

    localparam logic [LFSR_W-1:0] SEED = LFSR_W'(1) << FB_BIT;

    typedef struct packed {
        logic [LFSR_W-1:0] sr;
        logic              out;
    } core_t;

    core_t             st_d, st_q;
    logic              tap_b_on;
    logic              fb_bit;
    logic [LFSR_W-1:0] shifted;

    generate
        if (TAPB_ACTIVE_LOW) begin : g_tapb_low
            assign tap_b_on = ~st_q.sr[TAP_B];
        end else begin : g_tapb_high
            assign tap_b_on = st_q.sr[TAP_B];
        end
        if (RELOAD_ON_MODE_CHANGE) begin : g_reload_change
            assign reload = ctrl_we && (new_white != white);
        end else begin : g_reload_always
            assign reload = ctrl_we;
        end
    endgenerate

    always_comb begin
        st_d    = st_q;
        fb_bit  = st_q.sr[TAP_A] ^ (tap_b_on & white);
        shifted = (st_q.sr >> 1) | (fb_bit ? SEED : '0);
        if (reload) begin
            st_d.sr = SEED;
        end else if (shift_evt) begin
            st_d.sr  = shifted;
            st_d.out = shifted[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sr  <= SEED;
            st_q.out <= SEED[0];
        end else begin
            st_q <= st_d;
        end
    end

    assign lfsr      = st_q.sr;
    assign noise_out = st_q.out ^ INVERT_OUT;

endmodule

// File: rtl/noise_lfsr_gen.sv
module noise_lfsr_gen
    import noise_lfsr_pkg::*;
#(
    parameter int unsigned FB_BIT                = 15,
    parameter int unsigned TAP_A                 = 0,
    parameter int unsigned TAP_B                 = 3,
    parameter bit          TAPB_ACTIVE_LOW       = 1'b0,
    parameter bit          RELOAD_ON_MODE_CHANGE = 1'b0,
    parameter bit          INVERT_OUT            = 1'b0,
    parameter int unsigned TONE_W                = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ctrl_we,
    input  logic [2:0]        ctrl,
    input  logic [TONE_W-1:0] tone2_period,
    output logic              noise_out
);

    localparam int unsigned CNT_W  = TONE_W + 2;
    localparam int unsigned LFSR_W = FB_BIT + 1;

    typedef struct packed {
        noise_ctrl_t cfg;
    } top_t;

    top_t              st_d, st_q;
    noise_ctrl_t       wr_cfg;
    logic [CNT_W-1:0]  period;
    logic              shift_evt;
    logic              reload;
    logic [LFSR_W-1:0] lfsr_st;
    logic              mode_q;

    always_comb begin
        wr_cfg = noise_ctrl_t'(ctrl);
        st_d   = st_q;
        if (ctrl_we) st_d.cfg = wr_cfg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_q = st_q.cfg.white;

    noise_rate_sel #(.TONE_W(TONE_W), .CNT_W(CNT_W)) u_rate (
        .rate         (st_q.cfg.rate),
        .tone2_period (tone2_period),
        .period       (period)
    );

    noise_shift_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .period    (period),
        .shift_evt (shift_evt)
    );

    noise_lfsr_core #(
        .FB_BIT                (FB_BIT),
        .TAP_A                 (TAP_A),
        .TAP_B                 (TAP_B),
        .TAPB_ACTIVE_LOW       (TAPB_ACTIVE_LOW),
        .RELOAD_ON_MODE_CHANGE (RELOAD_ON_MODE_CHANGE),
        .INVERT_OUT            (INVERT_OUT)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_evt (shift_evt),
        .white     (mode_q),
        .ctrl_we   (ctrl_we),
        .new_white (wr_cfg.white),
        .reload    (reload),
        .lfsr      (lfsr_st),
        .noise_out (noise_out)
    );

endmodule

// File: rtl/noise_lfsr_chk.sv
module noise_lfsr_chk #(
    parameter int unsigned FB_BIT                = 15,
    parameter int unsigned TAP_A                 = 0,
    parameter int unsigned TAP_B                 = 3,
    parameter bit          TAPB_ACTIVE_LOW       = 1'b0,
    parameter bit          RELOAD_ON_MODE_CHANGE = 1'b0,
    parameter bit          INVERT_OUT            = 1'b0,
    localparam int unsigned LFSR_W               = FB_BIT + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              ctrl_we,
    input logic [2:0]        ctrl,
    input logic              mode_q,
    input logic              shift_evt,
    input logic              reload,
    input logic [LFSR_W-1:0] lfsr_st,
    input logic              noise_out
);

    localparam logic [LFSR_W-1:0] SEED = LFSR_W'(1) << FB_BIT;

    logic tapb_seen;
    assign tapb_seen = TAPB_ACTIVE_LOW ? ~lfsr_st[TAP_B] : lfsr_st[TAP_B];

    AST_SHIFT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        shift_evt |-> tick); // R2

    AST_TOP_BIT_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_evt && !reload) |=>
            lfsr_st[FB_BIT] == ($past(lfsr_st[TAP_A]) ^ ($past(tapb_seen) & $past(mode_q)))); // R4

    AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_evt && !reload) |=> lfsr_st[FB_BIT-1:0] == $past(lfsr_st[FB_BIT:1])); // R4

    AST_RELOAD_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> lfsr_st == SEED); // R6

    AST_SAME_MODE_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (RELOAD_ON_MODE_CHANGE && ctrl_we && (ctrl[2] == mode_q)) |-> !reload); // R7

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_evt && !reload) |=> $stable(noise_out)); // R8

    AST_OUT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_evt && !reload) |=> noise_out == (lfsr_st[0] ^ INVERT_OUT)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ctrl_we) |=> $stable(lfsr_st)); // R9

endmodule

bind noise_lfsr_gen noise_lfsr_chk #(
    .FB_BIT                (FB_BIT),
    .TAP_A                 (TAP_A),
    .TAP_B                 (TAP_B),
    .TAPB_ACTIVE_LOW       (TAPB_ACTIVE_LOW),
    .RELOAD_ON_MODE_CHANGE (RELOAD_ON_MODE_CHANGE),
    .INVERT_OUT            (INVERT_OUT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .ctrl_we   (ctrl_we),
    .ctrl      (ctrl),
    .mode_q    (mode_q),
    .shift_evt (shift_evt),
    .reload    (reload),
    .lfsr_st   (lfsr_st),
    .noise_out (noise_out)
);

// File: tb/noise_lfsr_gen_tb.sv
module noise_lfsr_gen_tb;

    localparam int TONE_W = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              ctrl_we = 1'b0;
    logic [2:0]        ctrl = 3'd0;
    logic [TONE_W-1:0] tone2_period = '0;
    logic              out_a, out_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    noise_lfsr_gen #(.TONE_W(TONE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_we(ctrl_we),
        .ctrl(ctrl), .tone2_period(tone2_period), .noise_out(out_a)
    );

    noise_lfsr_gen #(
        .FB_BIT(15), .TAP_A(1), .TAP_B(5), .TAPB_ACTIVE_LOW(1'b1),
        .RELOAD_ON_MODE_CHANGE(1'b1), .INVERT_OUT(1'b1), .TONE_W(TONE_W)
    ) u_dut_x (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_we(ctrl_we),
        .ctrl(ctrl), .tone2_period(tone2_period), .noise_out(out_b)
    );

    typedef struct {
        logic [31:0] lf;
        int          cnt;
        bit          out;
        logic [2:0]  cfg;
    } mdl_t;

    typedef struct {
        int fbb; int ta; int tb; bit low; bit chg; bit inv;
    } cfg_t;

    localparam cfg_t CA = '{15, 0, 3, 1'b0, 1'b0, 1'b0};
    localparam cfg_t CB = '{15, 1, 5, 1'b1, 1'b1, 1'b1};

    mdl_t ma, mb;

    function automatic mdl_t mdl_reset(cfg_t c);
        mdl_t m;
        m.lf = 32'd1 << c.fbb; m.cnt = 0; m.out = 1'b0; m.cfg = 3'd0;
        return m;
    endfunction

    function automatic mdl_t mdl_step(mdl_t m, cfg_t c, bit tk, bit we, logic [2:0] nc, int t2);
        mdl_t r = m;
        int   per;
        bit   sh = 1'b0;
        bit   rl;
        bit   a, b, fb;
        logic [31:0] nx;
        per = (m.cfg[1:0] == 2'd3) ? 2 * t2 : (32 << m.cfg[1:0]);
        if (tk) begin
            if (m.cnt <= 1) begin sh = 1'b1; r.cnt = per; end
            else r.cnt = m.cnt - 1;
        end
        rl = we && (!c.chg || (nc[2] != m.cfg[2]));
        a  = m.lf[c.ta];
        b  = c.low ? ~m.lf[c.tb] : m.lf[c.tb];
        fb = a ^ (b & m.cfg[2]);
        nx = (m.lf >> 1) | (fb ? (32'd1 << c.fbb) : 32'd0);
        if (rl) r.lf = 32'd1 << c.fbb;
        else if (sh) begin r.lf = nx; r.out = nx[0]; end
        if (we) r.cfg = nc;
        return r;
    endfunction

    task automatic check(string tag, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step(bit tk, bit we, logic [2:0] c, int t2, string tag);
        tick = tk; ctrl_we = we; ctrl = c; tone2_period = TONE_W'(t2);
        ma = mdl_step(ma, CA, tk, we, c, t2);
        mb = mdl_step(mb, CB, tk, we, c, t2);
        @(negedge clk);
        check(tag, out_a, ma.out ^ CA.inv);
        check({tag, " R7 R8 variant"}, out_b, mb.out ^ CB.inv);
    endtask

    task automatic count_high(int settle, int win, logic [2:0] c, int t2, int exp, string tag);
        int hi = 0;
        step(1'b1, 1'b1, c, t2, tag);
        for (int i = 0; i < settle; i++) step(1'b1, 1'b0, c, t2, tag);
        for (int i = 0; i < win; i++) begin
            step(1'b1, 1'b0, c, t2, tag);
            if (out_a) hi++;
        end
        checks++;
        if (hi != exp) begin
            fails++;
            $display("FAIL %s duty: actual %0d expected %0d", tag, hi, exp);
        end
    endtask

    task automatic rand_phase(int n, bit white_only, bit rate3, string tag);
        int t2 = 5;
        logic [2:0] c;
        for (int i = 0; i < n; i++) begin
            if (rate3 && (i % 50 == 0)) t2 = int'($urandom_range(0, 60));
            c[2]   = white_only ? 1'b1 : 1'($urandom_range(0, 1));
            c[1:0] = rate3 ? 2'd3 : 2'($urandom_range(0, 2));
            step(1'($urandom_range(0, 1)), ($urandom_range(0, 63) == 0), c, t2, tag);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        ma = mdl_reset(CA);
        mb = mdl_reset(CB);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", out_a, 1'b0);
        check("R1 reset variant", out_b, 1'b1);

        // R9: idle cycles leave everything unchanged
        for (int i = 0; i < 100; i++) step(1'b0, 1'b0, 3'b000, 7, "R9 idle");

        // R5: periodic, rate 0: high 32 of every 512 ticks
        count_high(600, 1024, 3'b000, 0, 64, "R5 periodic");
        // R3: periodic, rate 3, tone2=20: high 40 of every 640 ticks
        count_high(700, 1280, 3'b011, 20, 80, "R3 tone linked");
        // R10: tone2 period 0, shift every tick: high 1 of every 16
        count_high(50, 160, 3'b011, 0, 10, "R10 zero period");

        // R6 / R7: back-to-back writes with and without a mode change
        step(1'b1, 1'b1, 3'b100, 0, "R6 write");
        step(1'b1, 1'b1, 3'b100, 0, "R7 same mode");
        step(1'b1, 1'b1, 3'b000, 0, "R7 mode change");
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 3'b000, 0, "R6 after");

        rand_phase(3000, 1'b0, 1'b0, "R2 fixed rates");
        rand_phase(3000, 1'b1, 1'b0, "R4 white");
        rand_phase(3000, 1'b0, 1'b1, "R3 live period");
        for (int i = 0; i < 200; i++) step(1'b0, 1'b0, 3'b111, 9, "R9 idle late");
        rand_phase(2000, 1'b1, 1'b1, "R8 output");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule